// File: doc/BRIEF.md
# DDR SDRAM Refresh Scheduler

This block decides when a DDR SDRAM controller must spend command slots on refresh. A free-running interval counter produces one refresh obligation every `REF_INTERVAL` clock cycles. The default corresponds to a 7.8 µs average spacing (8192 refreshes per 64 ms) at a 4 ns clock. Obligations that cannot be served at once are held in a saturating pending counter, so the controller may postpone refreshes and later catch up with a burst. Once the controller reports that every bank is precharged, the scheduler emits a one-cycle auto-refresh command. It then marks the command bus busy for the refresh cycle time, `T_RFC` cycles.

The scheduler also drives the clock-enable line. When the controller asks for self-refresh and the banks are idle, a refresh command is issued in the same cycle that clock-enable falls. Clock-enable stays low for as long as the request is held. Dropping the request raises clock-enable again. Two exit windows then begin: non-read commands are blocked for `T_XSNR` cycles, and reads are blocked for `T_XSRD` cycles while the DLL, which comes back on by itself, relocks.

States: `ST_IDLE` (ready), `ST_AREF` (auto-refresh command cycle), `ST_RFC` (refresh cycle time), `ST_SREN` (self-refresh entry command), `ST_SELF` (clock-enable low), `ST_XNR` (exit, all commands blocked), `ST_XRD` (exit, reads only blocked). Transitions:
- IDLE→SREN on a self-refresh request with banks idle.
- IDLE→AREF on a pending refresh with banks idle.
- AREF→RFC always.
- RFC→IDLE when the timer expires.
- SREN→SELF always.
- SELF→XNR when the request drops.
- XNR→XRD when the non-read window ends.
- XRD→IDLE when the read window ends.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cke` is 1, and `ref_cmd`, `busy`, `rd_hold`, `urgent`, `ref_due` and `pend_cnt` are 0.
- R2: Outside self-refresh, one refresh obligation is added every `REF_INTERVAL` cycles. The interval counter restarts from zero at self-refresh exit. `pend_cnt` rises by one in the cycle after each interval ends, unless a refresh command is taken in that same cycle.
- R3: `pend_cnt` never exceeds `PEND_MAX` (8); an obligation arriving at the limit is dropped. `urgent` is 1 exactly when `pend_cnt` equals `PEND_MAX`.
- R4: In the ready state, with `pend_cnt` nonzero and `banks_idle` high, `ref_cmd` pulses for one cycle in the next cycle and `pend_cnt` drops by one. With `banks_idle` low, no command is issued.
- R5: `busy` is 1 for exactly `T_RFC` cycles, starting with the auto-refresh command cycle.
- R6: In the ready state, `sr_req` and `banks_idle` both high give, in the next cycle, `ref_cmd` = 1 with `cke` = 0. `cke` then stays 0 and `busy` 1 until the request is seen low. While `cke` is 0, `pend_cnt` is cleared.
- R7: When a self-refresh request and a pending auto-refresh are both eligible in the same cycle, self-refresh entry is taken.
- R8: `cke` returns to 1 in the cycle after `sr_req` is sampled low in self-refresh; `busy` stays 1 for `T_XSNR` cycles counted from that cycle.
- R9: `rd_hold` is 1 for `T_XSRD` cycles counted from the cycle `cke` returns high. A new self-refresh request is not taken until this window ends.
- R10: `ref_due` is 1 exactly when `pend_cnt` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| banks_idle | input | 1 | All banks precharged, from the controller |
| sr_req | input | 1 | Self-refresh request level |
| ref_cmd | output | 1 | Refresh command this cycle |
| cke | output | 1 | Clock-enable to the memory |
| busy | output | 1 | No command may be issued |
| rd_hold | output | 1 | No read may be issued (self-refresh exit) |
| ref_due | output | 1 | At least one refresh outstanding |
| urgent | output | 1 | Pending counter at its limit |
| pend_cnt | output | $clog2(PEND_MAX+1) | Outstanding refresh count |

## Verification
A wrong pending count shows at `pend_cnt`, `ref_due` and `urgent` in the cycle after the faulty update. It also changes whether a command follows an idle report one cycle later. A timer loaded off by one moves the falling edge of `busy` or `rd_hold` by one cycle at the end of the refresh or exit window, so a full window must be observed before the error is visible. A state that ignores priority or the idle input shows as a `ref_cmd` pulse with the wrong `cke` level, or at the wrong time.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AREF,
        ST_RFC,
        ST_SREN,
        ST_SELF,
        ST_XNR,
        ST_XRD
    } rfsh_state_e;

endpackage

// File: rtl/rfsh_tick.sv
// Interval counter: one tick per INTERVAL cycles, held at zero while halted.
module rfsh_tick #(
    parameter int INTERVAL = 1950
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    output logic tick
);
    localparam int W = $clog2(INTERVAL + 1);
    localparam logic [W-1:0] LAST = W'(INTERVAL - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (halt || cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + W'(1);
    end

    always_comb tick = !halt && (cnt == LAST);

    // R2: ticks are isolated pulses when the interval exceeds one cycle
    a_r2_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && INTERVAL > 1) |=> !tick);

endmodule

// File: rtl/rfsh_pend.sv
// Saturating count of outstanding refresh obligations.
module rfsh_pend #(
    parameter int PEND_MAX = 8,
    localparam int PW = $clog2(PEND_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          dec,
    input  logic          clr,
    output logic [PW-1:0] pend,
    output logic          urgent,
    output logic          due
);
    localparam logic [PW-1:0] LIMIT = PW'(PEND_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend <= '0;
        else if (clr)
            pend <= '0;
        else if (dec && !tick)
            pend <= pend - PW'(1);
        else if (tick && !dec && pend != LIMIT)
            pend <= pend + PW'(1);
    end

    always_comb begin
        urgent = (pend == LIMIT);
        due    = (pend != '0);
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= LIMIT);

    a_r3_hold_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == LIMIT && tick && !dec && !clr) |=> pend == LIMIT);

    a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dec && !clr && pend != LIMIT) |=> pend == $past(pend) + PW'(1));

    a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !tick && !clr) |=> pend == $past(pend) - PW'(1));

endmodule

// File: rtl/rfsh_fsm.sv
// Command sequencer: auto-refresh, self-refresh entry and exit windows.
module rfsh_fsm
    import rfsh_pkg::*;
#(
    parameter int T_RFC  = 18,
    parameter int T_XSNR = 19,
    parameter int T_XSRD = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic banks_idle,
    input  logic sr_req,
    input  logic due,
    output logic dec,
    output logic halt,
    output logic ref_cmd,
    output logic cke,
    output logic busy,
    output logic rd_hold
);
    localparam int TMAX = (T_RFC > T_XSRD) ? T_RFC : T_XSRD;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] LD_RFC = TW'(T_RFC - 2);
    localparam logic [TW-1:0] LD_XNR = TW'(T_XSNR - 1);
    localparam logic [TW-1:0] LD_XRD = TW'(T_XSRD - T_XSNR - 1);

    rfsh_state_e    state, state_n;
    logic [TW-1:0]  tmr, tmr_n;

    // next state and timer
    always_comb begin
        state_n = state;
        tmr_n   = tmr;
        unique case (state)
            ST_IDLE: begin
                if (sr_req && banks_idle)   state_n = ST_SREN;   // R7: self-refresh first
                else if (due && banks_idle) state_n = ST_AREF;
            end
            ST_AREF: begin
                state_n = ST_RFC;
                tmr_n   = LD_RFC;
            end
            ST_RFC: begin
                if (tmr == '0) state_n = ST_IDLE;
                else           tmr_n   = tmr - TW'(1);
            end
            ST_SREN: state_n = ST_SELF;
            ST_SELF: begin
                if (!sr_req) begin
                    state_n = ST_XNR;
                    tmr_n   = LD_XNR;
                end
            end
            ST_XNR: begin
                if (tmr == '0) begin
                    state_n = ST_XRD;
                    tmr_n   = LD_XRD;
                end else begin
                    tmr_n = tmr - TW'(1);
                end
            end
            ST_XRD: begin
                if (tmr == '0) state_n = ST_IDLE;
                else           tmr_n   = tmr - TW'(1);
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tmr   <= '0;
        end else begin
            state <= state_n;
            tmr   <= tmr_n;
        end
    end

    // outputs
    always_comb begin
        ref_cmd = 1'b0;
        cke     = 1'b1;
        busy    = 1'b0;
        rd_hold = 1'b0;
        halt    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_AREF: begin
                ref_cmd = 1'b1;
                busy    = 1'b1;
            end
            ST_RFC:  busy = 1'b1;
            ST_SREN: begin
                ref_cmd = 1'b1;
                cke     = 1'b0;
                busy    = 1'b1;
                halt    = 1'b1;
            end
            ST_SELF: begin
                cke  = 1'b0;
                busy = 1'b1;
                halt = 1'b1;
            end
            ST_XNR: begin
                busy    = 1'b1;
                rd_hold = 1'b1;
            end
            ST_XRD:  rd_hold = 1'b1;
            default: ;
        endcase
    end

    always_comb dec = (state == ST_IDLE) && (state_n == ST_AREF);

    a_r4_cmd_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_cmd) |-> $past(banks_idle));

    a_r5_busy_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |=> busy);

    a_r6_cke_falls_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> ref_cmd);

    a_r8_exit_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (busy && rd_hold));

    a_r6_cke_low_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && sr_req) |=> !cke);

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
    parameter int REF_INTERVAL = 1950,
    parameter int PEND_MAX     = 8,
    parameter int T_RFC        = 18,
    parameter int T_XSNR       = 19,
    parameter int T_XSRD       = 200
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          banks_idle,
    input  logic                          sr_req,
    output logic                          ref_cmd,
    output logic                          cke,
    output logic                          busy,
    output logic                          rd_hold,
    output logic                          ref_due,
    output logic                          urgent,
    output logic [$clog2(PEND_MAX+1)-1:0] pend_cnt
);
    logic tick, dec, halt;

    rfsh_tick #(.INTERVAL(REF_INTERVAL)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .halt (halt),
        .tick (tick)
    );

    rfsh_pend #(.PEND_MAX(PEND_MAX)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .dec   (dec),
        .clr   (halt),
        .pend  (pend_cnt),
        .urgent(urgent),
        .due   (ref_due)
    );

    rfsh_fsm #(.T_RFC(T_RFC), .T_XSNR(T_XSNR), .T_XSRD(T_XSRD)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .banks_idle(banks_idle),
        .sr_req    (sr_req),
        .due       (ref_due),
        .dec       (dec),
        .halt      (halt),
        .ref_cmd   (ref_cmd),
        .cke       (cke),
        .busy      (busy),
        .rd_hold   (rd_hold)
    );

    // R10: due flag and count agree
    a_r10_due_matches: assert property (@(posedge clk) disable iff (!rst_n)
        ref_due == (pend_cnt != '0));

endmodule

// File: tb/sim_rfsh_sched.sv
`timescale 1ns/1ps
module sim_rfsh_sched;
    localparam int IV   = 40;
    localparam int PMAX = 8;
    localparam int TRFC = 18;
    localparam int TXNR = 19;
    localparam int TXRD = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic banks_idle = 1'b0;
    logic sr_req = 1'b0;
    logic ref_cmd, cke, busy, rd_hold, ref_due, urgent;
    logic [3:0] pend_cnt;

    always #2 clk = ~clk;

    rfsh_sched #(.REF_INTERVAL(IV), .PEND_MAX(PMAX), .T_RFC(TRFC),
                 .T_XSNR(TXNR), .T_XSRD(TXRD)) u0 (
        .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .sr_req(sr_req),
        .ref_cmd(ref_cmd), .cke(cke), .busy(busy), .rd_hold(rd_hold),
        .ref_due(ref_due), .urgent(urgent), .pend_cnt(pend_cnt));

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural expectation: phase 0 ready, 1 refresh, 2 self-refresh, 3 exit
    int ph = 0, el = 0, iv = 0, pend = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R4/R6", "ref_cmd", int'(ref_cmd), int'(el == 0 && (ph == 1 || ph == 2)));
        chk("R6", "cke", int'(cke), int'(ph != 2));
        chk("R5/R8", "busy", int'(busy), int'(ph == 1 || ph == 2 || (ph == 3 && el < TXNR)));
        chk("R9", "rd_hold", int'(rd_hold), int'(ph == 3));
        chk("R2", "pend_cnt", int'(pend_cnt), pend);
        chk("R3", "urgent", int'(urgent), int'(pend == PMAX));
        chk("R10", "ref_due", int'(ref_due), int'(pend > 0));
    endtask

    // one clock: apply inputs at the falling edge, advance model, compare after the edge
    task automatic step(input bit idle, input bit sr);
        int np, nel, niv, npd;
        bit tk, dc;
        banks_idle = idle;
        sr_req = sr;
        tk = (ph != 2) && (iv == IV - 1);
        niv = (ph == 2 || iv == IV - 1) ? 0 : iv + 1;
        dc = 0; np = ph; nel = el;
        case (ph)
            0: if (sr && idle) begin np = 2; nel = 0; end       // R7: priority
               else if (pend > 0 && idle) begin np = 1; nel = 0; dc = 1; end
            1: if (el == TRFC - 1) np = 0; else nel = el + 1;
            2: if (el == 0) nel = 1; else if (!sr) begin np = 3; nel = 0; end
            default: if (el == TXRD - 1) np = 0; else nel = el + 1;
        endcase
        npd = pend;
        if (ph == 2) npd = 0;
        else if (dc && !tk) npd = pend - 1;
        else if (tk && !dc && pend < PMAX) npd = pend + 1;
        @(posedge clk);
        @(negedge clk);
        ph = np; el = nel; iv = niv; pend = npd;
        compare_all();
    endtask

    initial begin
        #700000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        if (!done) $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int r;
        void'($urandom(32'd4242));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "cke in reset", int'(cke), 1);
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "pend in reset", int'(pend_cnt), 0);
        chk("R1", "ref_cmd in reset", int'(ref_cmd), 0);
        rst_n = 1'b1;
        compare_all();
        // R3: banks never idle, count climbs to the limit and holds
        for (int i = 0; i < IV * (PMAX + 3); i++) step(1'b0, 1'b0);
        chk("R3", "saturated count", int'(pend_cnt), PMAX);
        chk("R3", "urgent at limit", int'(urgent), 1);
        // R4/R5: drain back-to-back
        for (int i = 0; i < 250; i++) step(1'b1, 1'b0);
        chk("R4", "drained", int'(pend_cnt), 0);
        // random idle pattern
        for (int i = 0; i < 3000; i++) begin
            r = $urandom % 4;
            step(r != 0, 1'b0);
        end
        // R7: build a backlog, then request self-refresh with banks idle
        while (pend < 2) step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        chk("R7", "self-refresh entry wins", int'(cke), 0);
        for (int i = 0; i < 30; i++) step(1'b1, 1'b1);
        chk("R6", "pending cleared in self-refresh", int'(pend_cnt), 0);
        // R8/R9: release, re-request early in the exit window
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
        for (int i = 0; i < TXRD + 20; i++) step(1'b1, 1'b1);
        chk("R9", "re-entry after read window", int'(cke), 0);
        for (int i = 0; i < TXRD + 10; i++) step(1'b0, 1'b0);
        // mixed random traffic with occasional self-refresh
        for (int i = 0; i < 6000; i++) begin
            r = $urandom % 100;
            if (r < 2) sr_req = ~sr_req;
            step(($urandom % 3) != 0, sr_req);
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule